// File: doc/BRIEF.md
# Watchdog Timer with Sticky Reset-Cause Flags

This block is a watchdog for a small 8-bit microcontroller. A free-running counter advances on every system clock and expires after one of four programmable time-outs chosen by a select input. When it expires, the block raises a sticky time-out flag. That flag, gated by an external interrupt enable, drives the watchdog interrupt. The time-out is then followed by a fixed grace window. If software has not restarted the count by the end of that window, and the reset function is enabled, the block issues a one-cycle reset request to the chip's reset controller.

All control and status sits in one 8-bit register on a plain register bus with address, write strobe, write data and combinational read data. The register also keeps two reset-cause flags: one for power-up and one for a reset caused by the watchdog. Both survive a warm (watchdog) reset and are cleared only by software writes. A power-on or power-fail reset sets the power-up flag and clears everything else. The register also stores one unrelated bit that doubles a serial-port baud rate and brings it out on a pin.

Top module: `wdt_guard`

## Requirements
- R1: The register at address CTRL_ADDR reads as bit 7 baud-double, bit 6 power-up flag, bits 5:4 zero, bit 3 time-out flag, bit 2 watchdog-reset flag, bit 1 reset enable, bit 0 zero. Any other address reads 0x00 and a write to it changes nothing.
- R2: While por_n is low, the register reads 0x40 and wdt_irq, wdt_rst_req and baud_dbl are all low.
- R3: The time-out flag (bit 3) is set exactly 2^(BASE_EXP + EXP_STEP*tsel) clock edges after the edge that sampled a restart.
- R4: The time-out flag is set whether or not the reset enable is 1. wdt_irq equals the time-out flag ANDed with irq_en.
- R5: A write with bit 0 set restarts the count from zero and cancels a pending grace window. Bit 0 always reads 0.
- R6: With the reset enable at 1, wdt_rst_req pulses high for exactly one cycle, GRACE_CYCLES edges after the time-out flag was set. The watchdog-reset flag (bit 2) reads 1 from that cycle on.
- R7: With the reset enable at 0, no reset request is issued and the watchdog-reset flag is not set by the watchdog.
- R8: The power-up, time-out and watchdog-reset flags are never cleared by hardware outside power-on reset. A write of 0 to the bit clears the flag.
- R9: A cycle with warm_rst high clears the reset enable, the baud-double bit, the count and any pending grace window. It keeps the power-up, time-out and watchdog-reset flags.
- R10: Bit 7 is stored on a write and driven on baud_dbl.
- R11: Bits 5:4 read 0 whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on / power-fail reset, active low, asynchronous |
| warm_rst | input | 1 | Synchronous warm reset, e.g. the watchdog reset fed back |
| tsel | input | SEL_W | Time-out select |
| irq_en | input | 1 | External watchdog interrupt enable |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data, combinational |
| wdt_irq | output | 1 | Watchdog interrupt |
| wdt_rst_req | output | 1 | One-cycle reset request to the reset controller |
| baud_dbl | output | 1 | Stored serial baud-doubling bit |

## Verification
The bench builds the block with BASE_EXP=4, EXP_STEP=1 and GRACE_CYCLES=8. This gives time-outs of 16, 32, 64 and 128 cycles and an 8-cycle grace window. At these values every time-out select, the exact edge of flag assertion and the exact edge of the reset pulse can be checked directly. So can a restart in the middle of a grace window and a warm reset that lands on a pending request, all within a short run.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    localparam int REG_W    = 8;
    localparam int BIT_BAUD = 7;
    localparam int BIT_POR  = 6;
    localparam int BIT_WDIF = 3;
    localparam int BIT_WTRF = 2;
    localparam int BIT_EWT  = 1;
    localparam int BIT_KICK = 0;

    typedef struct packed {
        logic baud;
        logic pwr_flag;
        logic tmo_flag;
        logic wdr_flag;
        logic rst_en;
    } ctrl_t;

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[BIT_BAUD] = c.baud;
        v[BIT_POR]  = c.pwr_flag;
        v[BIT_WDIF] = c.tmo_flag;
        v[BIT_WTRF] = c.wdr_flag;
        v[BIT_EWT]  = c.rst_en;
        return v;
    endfunction

endpackage

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int SEL_W    = 2,
    parameter int BASE_EXP = 17,
    parameter int EXP_STEP = 3
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             clear_i,
    input  logic [SEL_W-1:0] tsel_i,
    output logic             expire_o
);
    localparam int NUM_SEL = 1 << SEL_W;
    localparam int CNT_W   = BASE_EXP + EXP_STEP * (NUM_SEL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] last_val [NUM_SEL];
    logic hit;

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_limit
        assign last_val[g] = CNT_W'((64'd1 << (BASE_EXP + EXP_STEP * g)) - 64'd1);
    end

    assign hit      = (st_q.cnt == last_val[tsel_i]);
    assign expire_o = hit & ~clear_i;

    always_comb begin
        st_d = st_q;
        if (clear_i || hit) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdt_grace_timer.sv
module wdt_grace_timer #(
    parameter int GRACE_CYCLES = 512
) (
    input  logic clk,
    input  logic por_n,
    input  logic clear_i,
    input  logic start_i,
    input  logic rst_en_i,
    output logic fire_o,
    output logic wdr_set_o
);
    localparam int GR_W = (GRACE_CYCLES > 2) ? $clog2(GRACE_CYCLES) : 1;

    typedef struct packed {
        logic            act;
        logic [GR_W-1:0] cnt;
        logic            req;
    } grace_state_t;

    grace_state_t st_d, st_q;
    logic done;

    assign done      = st_q.act && (st_q.cnt == GR_W'(GRACE_CYCLES - 1));
    assign wdr_set_o = done & rst_en_i & ~clear_i;
    assign fire_o    = st_q.req;

    always_comb begin
        st_d     = st_q;
        st_d.req = wdr_set_o;
        if (clear_i) begin
            st_d.act = 1'b0;
            st_d.cnt = '0;
        end else if (start_i) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
        end else if (done) begin
            st_d.act = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.act) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_guard_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst_i,
    input  logic             wr_hit_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             tmo_set_i,
    input  logic             wdr_set_i,
    output ctrl_t            ctrl_o,
    output logic             kick_o
);
    ctrl_t st_d, st_q;
    logic  unused_wbits;

    assign unused_wbits = ^wdata_i[5:4];
    assign kick_o       = wr_hit_i & wdata_i[BIT_KICK];
    assign ctrl_o       = st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit_i) begin
            st_d.baud     = wdata_i[BIT_BAUD];
            st_d.pwr_flag = wdata_i[BIT_POR];
            st_d.tmo_flag = wdata_i[BIT_WDIF];
            st_d.wdr_flag = wdata_i[BIT_WTRF];
            st_d.rst_en   = wdata_i[BIT_EWT];
        end
        if (warm_rst_i) begin
            st_d.rst_en = 1'b0;
            st_d.baud   = 1'b0;
        end
        if (tmo_set_i) begin
            st_d.tmo_flag = 1'b1;
        end
        if (wdr_set_i) begin
            st_d.wdr_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q          <= '0;
            st_q.pwr_flag <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int              ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h1C,
    parameter int              SEL_W        = 2,
    parameter int              BASE_EXP     = 17,
    parameter int              EXP_STEP     = 3,
    parameter int              GRACE_CYCLES = 512
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst,
    input  logic [SEL_W-1:0]  tsel,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_rst_req,
    output logic              baud_dbl
);
    logic  wr_hit;
    logic  kick;
    logic  cnt_clear;
    logic  expire;
    logic  wdr_set;
    ctrl_t ctrl_q;

    assign wr_hit    = bus_wr && (bus_addr == CTRL_ADDR);
    assign cnt_clear = warm_rst | kick;

    wdt_ctrl_reg u_reg (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_i (warm_rst),
        .wr_hit_i   (wr_hit),
        .wdata_i    (bus_wdata),
        .tmo_set_i  (expire),
        .wdr_set_i  (wdr_set),
        .ctrl_o     (ctrl_q),
        .kick_o     (kick)
    );

    wdt_tick_counter #(
        .SEL_W    (SEL_W),
        .BASE_EXP (BASE_EXP),
        .EXP_STEP (EXP_STEP)
    ) u_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .clear_i  (cnt_clear),
        .tsel_i   (tsel),
        .expire_o (expire)
    );

    wdt_grace_timer #(
        .GRACE_CYCLES (GRACE_CYCLES)
    ) u_grace (
        .clk       (clk),
        .por_n     (por_n),
        .clear_i   (cnt_clear),
        .start_i   (expire),
        .rst_en_i  (ctrl_q.rst_en),
        .fire_o    (wdt_rst_req),
        .wdr_set_o (wdr_set)
    );

    assign bus_rdata = (bus_addr == CTRL_ADDR) ? pack_ctrl(ctrl_q) : 8'h00;
    assign wdt_irq   = ctrl_q.tmo_flag & irq_en;
    assign baud_dbl  = ctrl_q.baud;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
    import wdt_guard_pkg::*;
(
    input logic       clk,
    input logic       por_n,
    input logic       warm_rst,
    input logic       wr_hit,
    input logic       irq_en,
    input logic [7:0] bus_rdata,
    input logic       wdt_irq,
    input logic       wdt_rst_req,
    input logic       baud_dbl,
    input ctrl_t      ctrl
);

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rdata[5:4] == 2'b00) && !bus_rdata[0]); // R11

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!por_n)
        wdt_irq |-> (irq_en && ctrl.tmo_flag)); // R4

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |=> !wdt_rst_req); // R6

    AST_REQ_FLAGGED: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |-> ctrl.wdr_flag); // R6

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
        wdt_rst_req |-> $past(ctrl.rst_en)); // R7

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl.tmo_flag && !wr_hit) |=> ctrl.tmo_flag); // R8

    AST_PWR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl.pwr_flag && !wr_hit) |=> ctrl.pwr_flag); // R8

    AST_WDR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl.wdr_flag && !wr_hit) |=> ctrl.wdr_flag); // R8

    AST_WARM_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        warm_rst |=> (!ctrl.rst_en && !baud_dbl && !wdt_rst_req)); // R9

endmodule

bind wdt_guard wdt_guard_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .warm_rst    (warm_rst),
    .wr_hit      (wr_hit),
    .irq_en      (irq_en),
    .bus_rdata   (bus_rdata),
    .wdt_irq     (wdt_irq),
    .wdt_rst_req (wdt_rst_req),
    .baud_dbl    (baud_dbl),
    .ctrl        (ctrl_q)
);

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
    localparam int BASE  = 4;
    localparam int STEP  = 1;
    localparam int GRACE = 8;
    localparam logic [7:0] CA = 8'h1C;

    logic       clk = 1'b0;
    logic       por_n, warm_rst, irq_en, bus_wr;
    logic [1:0] tsel;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic       wdt_irq, wdt_rst_req, baud_dbl;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    wdt_guard #(
        .ADDR_W(8), .CTRL_ADDR(CA), .SEL_W(2),
        .BASE_EXP(BASE), .EXP_STEP(STEP), .GRACE_CYCLES(GRACE)
    ) dut (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst), .tsel(tsel),
        .irq_en(irq_en), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_irq(wdt_irq),
        .wdt_rst_req(wdt_rst_req), .baud_dbl(baud_dbl)
    );

    function automatic int limit(input int s);
        return 1 << (BASE + STEP * s);
    endfunction

    function automatic logic [7:0] read_model(input logic [7:0] d);
        return d & 8'hCE;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = CA;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic watch_req(input int n, output int first, output int cnt);
        first = -1;
        cnt   = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (wdt_rst_req) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int first, cnt, l0;
        logic [7:0] shadow, d;
        void'($urandom(32'h00C0FFEE));
        por_n = 1'b0; warm_rst = 1'b0; tsel = 2'd0; irq_en = 1'b0;
        bus_addr = CA; bus_wr = 1'b0; bus_wdata = 8'h00;
        idle(3);
        check(bus_rdata == 8'h40, "R2 reset value", bus_rdata, 8'h40);
        check({wdt_irq, wdt_rst_req, baud_dbl} == 3'b000, "R2 outputs low",
              {5'd0, wdt_irq, wdt_rst_req, baud_dbl}, 8'h00);
        @(negedge clk); por_n = 1'b1; #1;

        bus_addr = CA ^ 8'h01; #1;
        check(bus_rdata == 8'h00, "R1 other address reads zero", bus_rdata, 8'h00);
        bus_addr = CA; #1;

        // R8: power-up flag sticks through time-outs
        idle(40);
        check(bus_rdata[6] == 1'b1, "R8 power flag kept", bus_rdata, 8'h40);
        wr(CA, 8'h40);
        check(bus_rdata[6] == 1'b1, "R8 power flag after write 1", bus_rdata, 8'h40);

        // R3: time-out edge for every select, reset enable off
        for (int s = 0; s < 4; s++) begin
            tsel = s[1:0];
            wr(CA, 8'h01);
            idle(limit(s) - 1);
            check(bus_rdata[3] == 1'b0, $sformatf("R3 tsel=%0d flag before", s), bus_rdata, 8'h00);
            idle(1);
            check(bus_rdata[3] == 1'b1, $sformatf("R3 tsel=%0d flag at edge", s), bus_rdata, 8'h08);
        end

        // R4 / R7: flag set with enable off, irq gating, no request
        irq_en = 1'b0; #1;
        check(wdt_irq == 1'b0, "R4 irq masked", {7'd0, wdt_irq}, 8'h00);
        irq_en = 1'b1; #1;
        check(wdt_irq == 1'b1, "R4 irq follows flag", {7'd0, wdt_irq}, 8'h01);
        watch_req(GRACE + 4, first, cnt);
        check(cnt == 0, "R7 no request with enable off", 8'(cnt), 8'h00);
        check(bus_rdata[2] == 1'b0, "R7 reset flag untouched", bus_rdata, 8'h08);

        // R8: software write of 0 clears the time-out flag
        wr(CA, 8'h00);
        check(bus_rdata == 8'h00, "R8 write clears flags", bus_rdata, 8'h00);
        irq_en = 1'b0;

        // R6: request edge and width
        tsel = 2'd0;
        l0 = limit(0);
        wr(CA, 8'h03);
        watch_req(l0 + GRACE + 3, first, cnt);
        check(first == l0 + GRACE, "R6 request edge", 8'(first), 8'(l0 + GRACE));
        check(cnt == 1, "R6 request one cycle", 8'(cnt), 8'h01);
        check((bus_rdata & 8'h0C) == 8'h0C, "R6 reset flag set", bus_rdata, 8'h0E);
        idle(4);
        check(bus_rdata[2] == 1'b1, "R8 reset flag sticky", bus_rdata, 8'h0E);

        // R5: restart inside the grace window cancels the pending request
        wr(CA, 8'h03);
        idle(l0 + 2);
        wr(CA, 8'h03);
        check(bus_rdata[0] == 1'b0, "R5 restart bit reads zero", bus_rdata, 8'h02);
        watch_req(l0 + GRACE + 2, first, cnt);
        check(first == l0 + GRACE, "R5 request timed from restart", 8'(first), 8'(l0 + GRACE));

        // R9 / R10: warm reset during grace window
        wr(CA, 8'hCF);
        check(bus_rdata == 8'hCE, "R10 written value", bus_rdata, 8'hCE);
        check(baud_dbl == 1'b1, "R10 baud pin", {7'd0, baud_dbl}, 8'h01);
        idle(l0 + 2);
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0; #1;
        check(bus_rdata == 8'h4C, "R9 warm reset keeps flags", bus_rdata, 8'h4C);
        check(baud_dbl == 1'b0, "R9 baud cleared", {7'd0, baud_dbl}, 8'h00);
        watch_req(l0 + GRACE + 4, first, cnt);
        check(cnt == 0, "R9 pending request dropped", 8'(cnt), 8'h00);

        // R1 / R10 / R11: random writes, hits and misses
        tsel = 2'd3;
        wr(CA, 8'h01);
        shadow = 8'h00;
        for (int it = 0; it < 40; it++) begin
            d = 8'($urandom);
            if ($urandom % 2 == 0) begin
                wr(CA ^ 8'(1 + ($urandom % 7)), d);
                check(bus_rdata == shadow, "R1 miss write ignored", bus_rdata, shadow);
            end
            d[0] = 1'b1;
            wr(CA, d);
            shadow = read_model(d);
            check(bus_rdata == shadow, "R11 readback masks unused bits", bus_rdata, shadow);
            check(baud_dbl == shadow[7], "R10 baud pin random",
                  {7'd0, baud_dbl}, {7'd0, shadow[7]});
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule